// File: doc/BRIEF.md
# Serial Configuration Register Receiver

This block is the programming port of a clock-distribution device. A host drives three wires: a serial clock, a serial data line and an active-low latch enable. While the latch enable is low, each rising serial-clock edge shifts one bit into a 32-bit frame register, most significant bit first. When the latch enable goes high, the frame is committed. The last four bits shifted in select a register, and the 28 bits before them become that register's new contents.

Only a sparse set of addresses holds storage. A commit to any other address is dropped. The bank drives every register out in parallel, and each register has its own one-cycle write strobe. Bit 27 of register 0 is a global reset command. A frame that sets it restores the whole bank to its parameterised defaults and pulses a reset output. The other bits of that frame are ignored.

The three serial inputs are asynchronous to the system clock. They are synchronised, and their edges are detected in the system clock domain. The serial clock must run at no more than a quarter of the system clock rate.

Top module: `cfg_serial_rx`

## Requirements
- R1: After rst_ni is released, every implemented register reads its default value (DEF_SEED XOR register index), every unimplemented register reads zero, and no write strobe or reset pulse is active.
- R2: A frame is split as follows. The final 4 bits shifted form the address, and the 28 bits before them form the data. Bits arrive most significant first, so frame bit 31 is data bit 27.
- R3: Serial clock edges that occur while the latch enable is high do not change the frame register.
- R4: Register contents change only on a commit, which is a rising edge of the latch enable. A complete frame shifted with the latch enable held low leaves the bank unchanged.
- R5: The implemented addresses are 0 to 7, 11, 14 and 15. A commit to any other address changes no register and raises no strobe, and unimplemented registers always read zero.
- R6: Each commit to an implemented address, other than a reset command, raises only wr_stb_o[address], for exactly one system clock cycle.
- R7: A commit to address 0 with data bit 27 set returns every register to its default. It ignores the remaining data bits, pulses soft_rst_o for exactly one cycle, and raises no write strobe.
- R8: A commit to address 0 with data bit 27 clear stores the data in register 0, like any other write.
- R9: A frame of more or fewer than 32 serial clocks commits the 32 bits shifted most recently, including bits left over from earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_data_i | input | 1 | Serial data, most significant bit first |
| ser_le_ni | input | 1 | Active-low latch enable; its rising edge commits the frame |
| cfg_o | output | 448 | All 16 register slots, flattened; slot k is at [k*28 +: 28] |
| wr_stb_o | output | 16 | One-cycle write strobe per register |
| soft_rst_o | output | 1 | One-cycle pulse when the reset command is executed |

## Verification
The bench builds the block with the default 28-bit data and 4-bit address widths, the default sparse address mask, and a nonzero default seed. With a nonzero seed, a reset to defaults is distinguishable from a bank that is simply cleared. The serial clock is driven at one eighth of the system clock, which exercises the synchroniser at twice its minimum ratio. The full 16-entry address space, covering both implemented and missing slots, is reachable by random frames. Directed frames cover short and long frames, re-commits with no new bits, and the reset command carrying non-zero garbage in its other data bits.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  localparam int unsigned CFG_DATA_W = 28;
  localparam int unsigned CFG_ADDR_W = 4;
  localparam int unsigned CFG_SYNC_STAGES = 2;

  // default contents of slot idx
  function automatic logic [63:0] def_value(logic [63:0] seed, int unsigned idx);
    return seed ^ 64'(idx);
  endfunction
endpackage

// File: rtl/cfg_rx_sync.sv
module cfg_rx_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] in_i,
  output logic [WIDTH-1:0] lvl_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= in_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign lvl_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_rx_shifter.sv
module cfg_rx_shifter #(
  parameter int unsigned FRAME_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_en_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sh_q <= '0;
    else if (shift_en_i) sh_q <= {sh_q[FRAME_W-2:0], bit_i};
  end

  assign frame_o = sh_q;
endmodule

// File: rtl/cfg_rx_bank.sv
module cfg_rx_bank #(
  parameter int unsigned DATA_W  = 28,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned RST_BIT = DATA_W - 1,
  parameter logic [2**ADDR_W-1:0] IMPL_MASK = 16'hC8FF,
  parameter logic [DATA_W-1:0] DEF_SEED = '0,
  localparam int unsigned NUM_REGS = 2**ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          data_i,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o,
  output logic [NUM_REGS-1:0]        wr_stb_o,
  output logic                       soft_rst_o
);
  logic do_rst, do_wr, srst_q;

  assign do_rst = commit_i && (addr_i == '0) && data_i[RST_BIT];
  assign do_wr  = commit_i && !do_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_q <= 1'b0;
    else         srst_q <= do_rst;
  end
  assign soft_rst_o = srst_q;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
    localparam logic [DATA_W-1:0] DEF =
      DATA_W'(cfg_rx_pkg::def_value(64'(DEF_SEED), k));
    if (IMPL_MASK[k]) begin : g_impl
      logic [DATA_W-1:0] q;
      logic              stb_q;
      logic              hit;
      assign hit = do_wr && (addr_i == ADDR_W'(k));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q     <= DEF;
          stb_q <= 1'b0;
        end else begin
          stb_q <= hit;
          if (do_rst)   q <= DEF;
          else if (hit) q <= data_i;
        end
      end
      assign cfg_o[k*DATA_W +: DATA_W] = q;
      assign wr_stb_o[k]               = stb_q;
    end else begin : g_hole
      assign cfg_o[k*DATA_W +: DATA_W] = '0;
      assign wr_stb_o[k]               = 1'b0;
    end
  end
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx #(
  parameter int unsigned DATA_W  = cfg_rx_pkg::CFG_DATA_W,
  parameter int unsigned ADDR_W  = cfg_rx_pkg::CFG_ADDR_W,
  parameter int unsigned STAGES  = cfg_rx_pkg::CFG_SYNC_STAGES,
  parameter int unsigned RST_BIT = DATA_W - 1,
  parameter logic [2**ADDR_W-1:0] IMPL_MASK = 16'hC8FF,
  parameter logic [DATA_W-1:0] DEF_SEED = '0,
  localparam int unsigned NUM_REGS = 2**ADDR_W,
  localparam int unsigned FRAME_W  = DATA_W + ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ser_clk_i,
  input  logic                       ser_data_i,
  input  logic                       ser_le_ni,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o,
  output logic [NUM_REGS-1:0]        wr_stb_o,
  output logic                       soft_rst_o
);
  // bit 2: latch enable, bit 1: data, bit 0: serial clock
  logic [2:0] lvl;
  logic       sclk_prev_q, le_prev_q;
  logic       shift_en, commit;
  logic [FRAME_W-1:0] frame;

  cfg_rx_sync #(
    .WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({ser_le_ni, ser_data_i, ser_clk_i}),
    .lvl_o (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      le_prev_q   <= 1'b1;
    end else begin
      sclk_prev_q <= lvl[0];
      le_prev_q   <= lvl[2];
    end
  end

  assign shift_en = lvl[0] && !sclk_prev_q && !lvl[2];
  assign commit   = lvl[2] && !le_prev_q;

  cfg_rx_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(shift_en),
    .bit_i     (lvl[1]),
    .frame_o   (frame)
  );

  cfg_rx_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST_BIT(RST_BIT),
    .IMPL_MASK(IMPL_MASK), .DEF_SEED(DEF_SEED)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .addr_i    (frame[ADDR_W-1:0]),
    .data_i    (frame[FRAME_W-1:ADDR_W]),
    .cfg_o     (cfg_o),
    .wr_stb_o  (wr_stb_o),
    .soft_rst_o(soft_rst_o)
  );
endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk #(
  parameter int unsigned DATA_W = 28,
  parameter int unsigned ADDR_W = 4,
  parameter logic [2**ADDR_W-1:0] IMPL_MASK = 16'hC8FF,
  parameter logic [DATA_W-1:0] DEF_SEED = '0,
  localparam int unsigned NUM_REGS = 2**ADDR_W
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_REGS*DATA_W-1:0] cfg_o,
  input logic [NUM_REGS-1:0]        wr_stb_o,
  input logic                       soft_rst_o
);
  function automatic logic [NUM_REGS*DATA_W-1:0] defaults();
    logic [NUM_REGS*DATA_W-1:0] v;
    v = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (IMPL_MASK[k])
        v[k*DATA_W +: DATA_W] = DATA_W'(cfg_rx_pkg::def_value(64'(DEF_SEED), k));
    return v;
  endfunction

  function automatic logic holes_zero(logic [NUM_REGS*DATA_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NUM_REGS; k++)
      if (!IMPL_MASK[k] && v[k*DATA_W +: DATA_W] != '0) ok = 1'b0;
    return ok;
  endfunction

  p_stb_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_stb_o));
  p_stb_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_stb_o) |=> !(|wr_stb_o));
  p_hole_stb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o & ~IMPL_MASK) == '0);
  p_hole_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holes_zero(cfg_o));
  p_quiet_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|wr_stb_o) && !soft_rst_o) |-> cfg_o == $past(cfg_o));
  p_rst_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);
  p_rst_no_stb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> wr_stb_o == '0);
  p_rst_defaults_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> cfg_o == defaults());
endmodule

bind cfg_serial_rx cfg_serial_rx_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK), .DEF_SEED(DEF_SEED)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_o     (cfg_o),
  .wr_stb_o  (wr_stb_o),
  .soft_rst_o(soft_rst_o)
);

// File: tb/cfg_serial_rx_tb_top.sv
module cfg_serial_rx_tb_top;
  localparam int DW = 28;
  localparam int AW = 4;
  localparam int NR = 16;
  localparam logic [NR-1:0] MASK = 16'hC8FF;
  localparam logic [DW-1:0] SEED = 28'h9E37A5C;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, le_n = 1'b1;
  logic [NR*DW-1:0] cfg;
  logic [NR-1:0] stb;
  logic srst;

  always #4 clk = ~clk;

  cfg_serial_rx #(.IMPL_MASK(MASK), .DEF_SEED(SEED)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdat),
    .ser_le_ni(le_n), .cfg_o(cfg), .wr_stb_o(stb), .soft_rst_o(srst)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] model [NR];
  logic [31:0] msh = '0;
  int stb_cnt [NR];
  int exp_stb [NR];
  int rst_cnt = 0, exp_rst = 0;

  function automatic logic [DW-1:0] def_of(int k);
    return MASK[k] ? (SEED ^ DW'(k)) : '0;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    for (int k = 0; k < NR; k++) if (stb[k]) stb_cnt[k]++;
    if (srst) rst_cnt++;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = v[i];
      sclk = 1'b0;
      wait_clk(HALF);
      sclk = 1'b1;
      if (!le_n) msh = {msh[30:0], v[i]};
      wait_clk(HALF);
    end
    sclk = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic apply_commit();
    logic [3:0] a;
    logic [DW-1:0] d;
    a = msh[3:0];
    d = msh[31:4];
    if (a == 0 && d[27]) begin
      for (int k = 0; k < NR; k++) model[k] = def_of(k);
      exp_rst++;
    end else if (MASK[a]) begin
      model[a] = d;
      exp_stb[a]++;
    end
  endtask

  task automatic raise_le();
    le_n = 1'b1;
    apply_commit();
    wait_clk(8);
  endtask

  task automatic send_frame(input logic [63:0] v, input int n);
    le_n = 1'b0;
    wait_clk(HALF);
    send_bits(v, n);
    raise_le();
  endtask

  task automatic check_bank(input string req);
    for (int k = 0; k < NR; k++)
      chk(cfg[k*DW +: DW] == model[k], req, 64'(cfg[k*DW +: DW]), 64'(model[k]));
    for (int k = 0; k < NR; k++)
      chk(stb_cnt[k] == exp_stb[k], {req, " strobe count"}, 64'(stb_cnt[k]), 64'(exp_stb[k]));
    chk(rst_cnt == exp_rst, {req, " reset pulses"}, 64'(rst_cnt), 64'(exp_rst));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    wait_clk(150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    logic [3:0] a;
    void'($urandom(32'd2024));
    for (int k = 0; k < NR; k++) begin
      model[k] = def_of(k);
      stb_cnt[k] = 0;
      exp_stb[k] = 0;
    end
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 reset state
    check_bank("R1");
    @(negedge clk);
    chk(srst == 1'b0 && stb == '0, "R1 idle outputs", 64'({srst, stb}), 64'(0));

    // R2 directed write, MSB first
    send_frame({28'hABCDEF1, 4'd5}, 32);
    check_bank("R2");

    // R4 no change before latch rises
    le_n = 1'b0;
    wait_clk(HALF);
    send_bits({28'h1234567, 4'd3}, 32);
    wait_clk(8);
    chk(cfg[3*DW +: DW] == def_of(3), "R4 before commit", 64'(cfg[3*DW +: DW]), 64'(def_of(3)));
    raise_le();
    check_bank("R4");

    // R5 unimplemented addresses
    send_frame({28'hFFFFFFF, 4'd9}, 32);
    send_frame({28'h0F0F0F0, 4'd12}, 32);
    send_frame({28'h5555555, 4'd13}, 32);
    check_bank("R5");

    // R8 ordinary register 0 write
    send_frame({28'h7654321, 4'd0}, 32);
    check_bank("R8");
    send_frame({28'h00000AA, 4'd11}, 32);
    send_frame({28'h0000BBB, 4'd15}, 32);

    // R7 reset command with garbage bits
    send_frame({28'hF3C5A96, 4'd0}, 32);
    check_bank("R7");
    chk(cfg[0 +: DW] == def_of(0), "R7 reg0 ignores data", 64'(cfg[0 +: DW]), 64'(def_of(0)));

    // R3 clocks with latch high are ignored; re-commit repeats last frame
    send_frame({28'h0C0FFEE, 4'd6}, 32);
    send_bits(64'h3FF, 10);
    send_frame(64'h0, 0);
    check_bank("R3");

    // R9 short and long frames
    send_frame(64'h0000000000000072, 8);
    check_bank("R9 short");
    send_frame({8'hAB, 28'h1111111, 4'd2}, 40);
    check_bank("R9 long");

    // R2 R6 random frames
    for (int i = 0; i < 40; i++) begin
      a = 4'($urandom_range(0, 15));
      d = DW'($urandom);
      if (a == 0 && ($urandom_range(0, 3) != 0)) d[27] = 1'b0;
      send_frame({d, a}, 32);
      check_bank("R6 random");
    end
    finish_run();
  end
endmodule